// File: doc/BRIEF.md
# Word-Parallel Grain-128 Initialization Engine

This block runs the Grain-128 initialization phase thirty-two rounds per clock. A load strobe fills the nonlinear register with a 128-bit key and the linear register with a 96-bit IV plus thirty-two ones. Each following clock advances both registers by one 32-bit word. During that clock the block presents a word of pre-output bits, one bit per round, so a single run yields the first keystream bit for every round count up to the programmed limit.

The limit is programmed as a number of 32-round steps. When the step count reaches the limit, the engine stops, holds its state and raises a done flag. It is intended for distinguisher experiments that sum the first output bit over many IVs for a range of reduced round counts.

Top module: `grain32_core`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle: `busy`=0, `done`=0, `step`=0 and both registers cleared, so `pre_word`=0. `rst` takes priority over `load`.
- R2: A clock edge with `load`=1 sets nonlinear register bit i to `key[i]`, linear register bit i to `iv[i]` for i<96 and to 1 for 96..127, and clears `step` to 0. A load during a run abandons that run and starts the new one.
- R3: With bit 0 as the lowest index, each round computes y = b12·s8 ^ s13·s20 ^ b95·s42 ^ s60·s79 ^ b12·b95·s95 ^ s93 ^ b2 ^ b15 ^ b36 ^ b45 ^ b64 ^ b73 ^ b89. It then shifts both registers toward index 0 and inserts new s127 = s0^s7^s38^s70^s81^s96^y and new b127 = s0^b0^b26^b56^b91^b96^b3·b67^b11·b13^b17·b18^b27·b59^b40·b48^b61·b65^b68·b84^y.
- R4: While `busy`=1 with `step`=i, bit j of `pre_word` is the y of round 32i+j, and `step` increases by one each clock.
- R5: With a limit L of 1..8 in `round_words`, `busy` stays high for exactly L cycles after the load edge. On the next edge `busy` falls, `done` rises and `step` shows L.
- R6: `round_words`=0 gives `done`=1 right after the load edge, with no busy cycle.
- R7: Values of `round_words` above 8 act as 8.
- R8: While `done`=1 and no load occurs, the state is frozen. `pre_word` then holds y for rounds 32L..32L+31, so its bit 0 is the first keystream bit after 32L rounds.
- R9: `busy` and `done` are never high together, and `done` rises only after a busy cycle or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture key, IV and limit; start a run |
| key | input | 128 | Key for the nonlinear register |
| iv | input | 96 | IV for the low linear-register positions |
| round_words | input | 4 | Limit in 32-round steps (0..8, larger saturates) |
| busy | output | 1 | Engine advancing this cycle |
| done | output | 1 | Limit reached; state frozen |
| step | output | 4 | Number of 32-round steps completed |
| pre_word | output | 32 | Pre-output bits of the 32 rounds of this step |

## Verification
A bit-serial model in the bench produces y for every round. The bench compares it against each word with keys and IVs that are random, all-zero and all-one. A wrong tap or a wrong bit order inside the word shows up as miscompares from the first word. If the output word were fed back into only one register, the run would diverge after the first step. The bench also probes limits 0, 1, 3 and 12. An off-by-one counter would emit one word too many or too few. A missing saturation would run 12 steps. A load in the middle of a run must discard the old run, or the queue of expected words is left unbalanced. Freezing after done is checked over several idle cycles.

// File: rtl/grain32_pkg.sv
package grain32_pkg;
    localparam int REG_W     = 128;
    localparam int IV_W      = 96;
    localparam int WORD_W    = 32;
    localparam int MAX_WORDS = (2 * REG_W) / WORD_W;
    localparam int CNT_W     = $clog2(MAX_WORDS) + 1;
    localparam int PAD_W     = REG_W - IV_W;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        reg_t nl;   // nonlinear register (key side)
        reg_t ln;   // linear register (IV side)
    } gstate_t;

    function automatic logic lin_fb(input reg_t s, input int k);
        return s[k] ^ s[k+7] ^ s[k+38] ^ s[k+70] ^ s[k+81] ^ s[k+96];
    endfunction

    function automatic logic nl_fb(input reg_t b, input int k);
        return b[k] ^ b[k+26] ^ b[k+56] ^ b[k+91] ^ b[k+96]
             ^ (b[k+3]  & b[k+67]) ^ (b[k+11] & b[k+13])
             ^ (b[k+17] & b[k+18]) ^ (b[k+27] & b[k+59])
             ^ (b[k+40] & b[k+48]) ^ (b[k+61] & b[k+65])
             ^ (b[k+68] & b[k+84]);
    endfunction

    function automatic logic pre_bit(input reg_t b, input reg_t s, input int k);
        logic hv;
        hv = (b[k+12] & s[k+8]) ^ (s[k+13] & s[k+20]) ^ (b[k+95] & s[k+42])
           ^ (s[k+60] & s[k+79]) ^ (b[k+12] & b[k+95] & s[k+95]);
        return hv ^ s[k+93] ^ b[k+2] ^ b[k+15] ^ b[k+36] ^ b[k+45]
             ^ b[k+64] ^ b[k+73] ^ b[k+89];
    endfunction
endpackage

// File: rtl/grain32_round.sv
module grain32_round
    import grain32_pkg::*;
(
    input  gstate_t cur,
    output word_t   ln_top,
    output word_t   nl_top,
    output word_t   y_word
);
    for (genvar k = 0; k < WORD_W; k++) begin : g_lane
        assign y_word[k] = pre_bit(cur.nl, cur.ln, k);
        assign ln_top[k] = lin_fb(cur.ln, k) ^ y_word[k];
        assign nl_top[k] = cur.ln[k] ^ nl_fb(cur.nl, k) ^ y_word[k];
    end
endmodule

// File: rtl/grain32_ctrl.sv
module grain32_ctrl
    import grain32_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t limit_in,
    output logic busy,
    output logic done,
    output cnt_t step
);
    cnt_t lim_eff;
    cnt_t lim_q;

    assign lim_eff = (limit_in > cnt_t'(MAX_WORDS)) ? cnt_t'(MAX_WORDS) : limit_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            step  <= '0;
            lim_q <= '0;
        end else if (load) begin
            step  <= '0;
            lim_q <= lim_eff;
            busy  <= (lim_eff != '0);
            done  <= (lim_eff == '0);
        end else if (busy) begin
            step <= step + cnt_t'(1);
            if (step + cnt_t'(1) == lim_q) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R9
    done_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) || $past(load)));

    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (step == $past(step) + cnt_t'(1)));

    // R7
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step < cnt_t'(MAX_WORDS)));
endmodule

// File: rtl/grain32_core.sv
module grain32_core
    import grain32_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [REG_W-1:0]    key,
    input  logic [IV_W-1:0]     iv,
    input  logic [CNT_W-1:0]    round_words,
    output logic                busy,
    output logic                done,
    output logic [CNT_W-1:0]    step,
    output logic [WORD_W-1:0]   pre_word
);
    gstate_t st_q;
    word_t   ln_top;
    word_t   nl_top;

    grain32_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .limit_in (round_words),
        .busy     (busy),
        .done     (done),
        .step     (step)
    );

    grain32_round i_round (
        .cur    (st_q),
        .ln_top (ln_top),
        .nl_top (nl_top),
        .y_word (pre_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q.nl <= key;
            st_q.ln <= {{PAD_W{1'b1}}, iv};
        end else if (busy) begin
            st_q.nl <= {nl_top, st_q.nl[REG_W-1:WORD_W]};
            st_q.ln <= {ln_top, st_q.ln[REG_W-1:WORD_W]};
        end
    end

    // R2
    load_fill_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (st_q.nl == $past(key)) && (st_q.ln[IV_W-1:0] == $past(iv))
                 && (st_q.ln[REG_W-1:IV_W] == {PAD_W{1'b1}}));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> $stable(st_q));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && st_q == '0));
endmodule

// File: tb/test_grain32_core.sv
module test_grain32_core;
    import grain32_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [127:0] key = '0;
    logic [95:0]  iv = '0;
    logic [3:0]   round_words = '0;
    logic        busy, done;
    logic [3:0]  step;
    logic [31:0] pre_word;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] expq[$];

    always #5 clk = ~clk;

    grain32_core i_grain32_core (
        .clk(clk), .rst(rst), .load(load), .key(key), .iv(iv),
        .round_words(round_words), .busy(busy), .done(done),
        .step(step), .pre_word(pre_word)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bit-serial model of the requirement R3 round
    task automatic ref_run(input logic [127:0] k, input logic [95:0] v,
                           output logic [287:0] ys);
        logic [127:0] b, s;
        logic y, fb_s, fb_b;
        b = k;
        s = {32'hFFFF_FFFF, v};
        for (int r = 0; r < 288; r++) begin
            y = (b[12] & s[8]) ^ (s[13] & s[20]) ^ (b[95] & s[42])
              ^ (s[60] & s[79]) ^ (b[12] & b[95] & s[95])
              ^ s[93] ^ b[2] ^ b[15] ^ b[36] ^ b[45] ^ b[64] ^ b[73] ^ b[89];
            ys[r] = y;
            fb_s = s[0] ^ s[7] ^ s[38] ^ s[70] ^ s[81] ^ s[96] ^ y;
            fb_b = s[0] ^ b[0] ^ b[26] ^ b[56] ^ b[91] ^ b[96]
                 ^ (b[3] & b[67]) ^ (b[11] & b[13]) ^ (b[17] & b[18])
                 ^ (b[27] & b[59]) ^ (b[40] & b[48]) ^ (b[61] & b[65])
                 ^ (b[68] & b[84]) ^ y;
            s = {fb_s, s[127:1]};
            b = {fb_b, b[127:1]};
        end
    endtask

    // driver: abort_at < 0 runs to completion, otherwise reloads after that many words
    task automatic run(input logic [127:0] k, input logic [95:0] v,
                       input logic [3:0] rw, input int abort_at);
        logic [287:0] ys;
        int lim;
        int npush;
        lim = (rw > 8) ? 8 : int'(rw);
        ref_run(k, v, ys);
        npush = (abort_at >= 0) ? abort_at : lim;
        for (int i = 0; i < npush; i++) expq.push_back(ys[32*i +: 32]);
        key = k; iv = v; round_words = rw; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        if (abort_at >= 0) begin
            repeat (abort_at - 1) @(negedge clk);
            chk("R9 restart busy", 64'(busy), 64'd1);
        end else begin
            if (lim > 0) chk("R4 first step", 64'(step), 64'd0);
            repeat (lim) @(negedge clk);
            chk("R5 done flag", 64'(done), 64'd1);
            chk("R5 busy low", 64'(busy), 64'd0);
            chk("R5 step count", 64'(step), 64'(lim));
            chk("R7 word count", 64'(expq.size()), 64'd0);
            chk("R8 final word", 64'(pre_word), 64'(ys[32*lim +: 32]));
            repeat (3) @(negedge clk);
            chk("R8 held word", 64'(pre_word), 64'(ys[32*lim +: 32]));
            chk("R8 held done", 64'(done), 64'd1);
        end
    endtask

    // monitor: scoreboard pop on every busy cycle
    initial begin
        forever begin
            @(negedge clk);
            if (busy && !rst) begin
                if (expq.size() == 0) begin
                    chk("R5 extra busy word", 64'(pre_word), 64'hDEAD);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk("R4 pre_word", 64'(pre_word), 64'(e));
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 pre_word", 64'(pre_word), 64'd0);
        // R1: reset wins over load
        key = '1; load = 1'b1; round_words = 4'd8;
        @(negedge clk);
        chk("R1 rst over load", 64'({busy, done}), 64'd0);
        chk("R1 rst over load word", 64'(pre_word), 64'd0);
        load = 1'b0; rst = 1'b0;
        @(negedge clk);

        // R2 R3 R4 R5: full-length and partial runs
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd8, -1);
        run('0, '0, 4'd8, -1);
        run('1, '1, 4'd3, -1);
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd1, -1);
        // R6: zero limit
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd0, -1);
        // R7: saturating limit
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd12, -1);
        // R9: load mid-run restarts
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd8, 3);
        run({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom}, 4'd5, -1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule